// File: doc/BRIEF.md
# Programmable Event Counter Bank

This block holds a set of 64-bit counters that software configures and reads through a 12-bit register address space. The core supplies a packed vector of 96 event lanes every clock. Each lane is an 8-bit count of how many times that event happened in the cycle. Every counter owns a selector that names one lane, and every clock the counter adds that lane's count. A shared freeze mask can stop individual counters, and software may load any counter, selector or the mask at any time.

The register port is a plain one-cycle interface. `reg_addr` picks a register and `reg_rdata` shows its current contents in the same cycle. When `reg_wr` is high, the rising clock edge stores `reg_wdata`. Counter slots are numbered 3 to 31, and their register addresses follow from the slot number.

Top module: `hpm_counter_bank`

## Requirements
- R1: After a synchronous active-low reset, every counter, every selector and the freeze mask read as zero.
- R2: Counter slot n (3..31) is read and written at address 0xB00+n. A write loads the full 64-bit value, which is visible from the next cycle.
- R3: The selector of slot n is at address 0x320+n. It stores only the low 7 bits of a write and reads back zero-extended to 64 bits.
- R4: The freeze mask is at address 0x320. Bit n belongs to slot n. Only bits 3..31 are stored, so bits 0..2 and 32..63 always read zero.
- R5: Every cycle, each counter that is not frozen adds its selected lane. Lane k occupies bits [8k+7:8k] of `evt_lanes`. A selector or mask write affects the increment only from the following cycle.
- R6: A selector value of 0, or a value of 96 or above, adds nothing. Lane 0 never counts, whatever it carries.
- R7: While mask bit n is set, counter n holds its value.
- R8: In a cycle where software writes a counter, the written value is stored and that cycle's increment is dropped.
- R9: Counters wrap modulo 2^64 and raise no flag.
- R10: An address outside the three decoded groups reads as zero, and a write to it changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_lanes | input | 768 | 96 event lanes of 8 bits, lane k at bits [8k+7:8k] |
| reg_addr | input | 12 | Register address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Contents of the addressed register, combinational |

## Verification
Directed steps first load a lane of 0xFF on a single selected slot, so that a wrong lane index or byte offset shows up as a wrong sum. Other directed steps put a nonzero value on lane 0 and point selectors at 0 and at values of 96 or above, which separates "no event" from "lane 0". A counter write and an increment land in the same cycle near 2^64, which shows both the priority between them and the wrap. After that, a long random run mixes writes to counters, selectors, the mask and unmapped addresses with random lane contents and compares every read against a bench model. In that run, mask bits are random, so frozen and running counters are exercised side by side.

// File: rtl/hpm_pkg.sv
// Package: shared constants and types of the event counter bank.
// Assumes a 12-bit register address space.
package hpm_pkg;
    localparam int unsigned ADDR_W   = 12;
    localparam logic [ADDR_W-1:0] CTR_BASE = 12'hB00;
    localparam logic [ADDR_W-1:0] SEL_BASE = 12'h320;

    // Which register group an address falls in.
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CTR  = 2'd1,
        RGN_SEL  = 2'd2,
        RGN_MASK = 2'd3
    } region_e;
endpackage

// File: rtl/hpm_addr_decode.sv
// Module: hpm_addr_decode
// Maps a register address onto a group (counter, selector, mask or none)
// and a zero-based slot index. Slots are FIRST_IDX..FIRST_IDX+NUM_CTR-1.
// Assumes the selector group never reaches offset 0, which belongs to the mask.
module hpm_addr_decode
    import hpm_pkg::*;
#(
    parameter int unsigned FIRST_IDX = 3,
    parameter int unsigned NUM_CTR   = 29,
    localparam int unsigned IDX_W    = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  slot
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(FIRST_IDX);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(FIRST_IDX + NUM_CTR);

    logic [ADDR_W-1:0] ctr_off;
    logic [ADDR_W-1:0] sel_off;

    // Offsets from each group base; an address below a base wraps out of range.
    always_comb begin
        ctr_off = addr - CTR_BASE;
        sel_off = addr - SEL_BASE;
    end

    // Group and slot selection.
    always_comb begin
        region = RGN_NONE;
        slot   = '0;
        if (ctr_off >= LO && ctr_off < HI) begin
            region = RGN_CTR;
            slot   = IDX_W'(ctr_off - LO);
        end else if (sel_off >= LO && sel_off < HI) begin
            region = RGN_SEL;
            slot   = IDX_W'(sel_off - LO);
        end else if (sel_off == '0) begin
            region = RGN_MASK;
        end
    end
endmodule

// File: rtl/hpm_lane_pick.sv
// Module: hpm_lane_pick
// Returns the count carried by the lane a selector names. Lane 0 and any
// selector at or above NUM_EVT give zero.
// Assumes lane k sits at bits [EVT_W*k +: EVT_W] of the packed vector.
module hpm_lane_pick #(
    parameter int unsigned NUM_EVT = 96,
    parameter int unsigned EVT_W   = 8,
    parameter int unsigned SEL_W   = 7
) (
    input  logic [NUM_EVT*EVT_W-1:0] lanes,
    input  logic [SEL_W-1:0]         sel,
    output logic [EVT_W-1:0]         count
);
    // Lane multiplexer with the null and out-of-range cases masked.
    always_comb begin
        count = '0;
        if (sel != '0 && 32'(sel) < NUM_EVT) begin
            count = lanes[32'(sel)*EVT_W +: EVT_W];
        end
    end
endmodule

// File: rtl/hpm_counter_slice.sv
// Module: hpm_counter_slice
// Holds one counter and its selector. Every cycle the counter either loads
// software data or, unless frozen, adds the selected lane count.
// Assumes the write strobes are already decoded for this slot.
module hpm_counter_slice #(
    parameter int unsigned CTR_W   = 64,
    parameter int unsigned NUM_EVT = 96,
    parameter int unsigned EVT_W   = 8,
    parameter int unsigned SEL_W   = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_EVT*EVT_W-1:0] lanes,
    input  logic                     frozen,
    input  logic                     ctr_we,
    input  logic                     sel_we,
    input  logic [CTR_W-1:0]         wdata,
    output logic [CTR_W-1:0]         ctr_q,
    output logic [SEL_W-1:0]         sel_q
);
    logic [EVT_W-1:0] inc;

    hpm_lane_pick #(
        .NUM_EVT(NUM_EVT),
        .EVT_W  (EVT_W),
        .SEL_W  (SEL_W)
    ) u_pick (
        .lanes(lanes),
        .sel  (sel_q),
        .count(inc)
    );

    // Counter: a software load beats the increment; the sum wraps at the width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else if (ctr_we) begin
            ctr_q <= wdata;
        end else if (!frozen) begin
            ctr_q <= ctr_q + CTR_W'(inc);
        end
    end

    // Selector: keeps only the low SEL_W bits of a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_we) begin
            sel_q <= wdata[SEL_W-1:0];
        end
    end
endmodule

// File: rtl/hpm_counter_bank.sv
// Module: hpm_counter_bank (top)
// A bank of NUM_CTR event counters with per-slot lane selectors and a shared
// freeze mask, all reached through a one-cycle register port. Reads are
// combinational; writes land on the clock edge.
// Assumes FIRST_IDX + NUM_CTR <= 32 so the mask fits the low word.
module hpm_counter_bank
    import hpm_pkg::*;
#(
    parameter int unsigned FIRST_IDX = 3,
    parameter int unsigned NUM_CTR   = 29,
    parameter int unsigned CTR_W     = 64,
    parameter int unsigned NUM_EVT   = 96,
    parameter int unsigned EVT_W     = 8,
    localparam int unsigned SEL_W    = $clog2(NUM_EVT),
    localparam int unsigned IDX_W    = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_EVT*EVT_W-1:0] evt_lanes,
    input  logic [11:0]              reg_addr,
    input  logic                     reg_wr,
    input  logic [CTR_W-1:0]         reg_wdata,
    output logic [CTR_W-1:0]         reg_rdata
);
    region_e          region;
    logic [IDX_W-1:0] slot;
    logic [NUM_CTR-1:0] frz_q;
    logic [CTR_W-1:0] ctr_q [NUM_CTR];
    logic [SEL_W-1:0] sel_q [NUM_CTR];

    hpm_addr_decode #(
        .FIRST_IDX(FIRST_IDX),
        .NUM_CTR  (NUM_CTR)
    ) u_dec (
        .addr  (reg_addr),
        .region(region),
        .slot  (slot)
    );

    // Freeze mask: bit FIRST_IDX+i of the data word freezes slot i.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frz_q <= '0;
        end else if (reg_wr && region == RGN_MASK) begin
            frz_q <= reg_wdata[FIRST_IDX +: NUM_CTR];
        end
    end

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_slice
        logic hit;
        // Slot match for this slice's write strobes.
        always_comb hit = reg_wr && (slot == IDX_W'(i));

        hpm_counter_slice #(
            .CTR_W  (CTR_W),
            .NUM_EVT(NUM_EVT),
            .EVT_W  (EVT_W),
            .SEL_W  (SEL_W)
        ) u_slice (
            .clk   (clk),
            .rst_n (rst_n),
            .lanes (evt_lanes),
            .frozen(frz_q[i]),
            .ctr_we(hit && region == RGN_CTR),
            .sel_we(hit && region == RGN_SEL),
            .wdata (reg_wdata),
            .ctr_q (ctr_q[i]),
            .sel_q (sel_q[i])
        );
    end

    // Read mux: narrow registers are zero-extended, unmapped addresses give zero.
    always_comb begin
        reg_rdata = '0;
        case (region)
            RGN_CTR:  reg_rdata = ctr_q[slot];
            RGN_SEL:  reg_rdata = CTR_W'(sel_q[slot]);
            RGN_MASK: reg_rdata = CTR_W'({frz_q, {FIRST_IDX{1'b0}}});
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/hpm_counter_bank_chk.sv
// Module: hpm_counter_bank_chk
// Port-level properties of the counter bank, attached by bind.
// Assumes the default address map bases from hpm_pkg.
module hpm_counter_bank_chk
    import hpm_pkg::*;
#(
    parameter int unsigned FIRST_IDX = 3,
    parameter int unsigned NUM_CTR   = 29,
    parameter int unsigned CTR_W     = 64,
    parameter int unsigned SEL_W     = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic [11:0]        reg_addr,
    input logic               reg_wr,
    input logic [CTR_W-1:0]   reg_wdata,
    input logic [CTR_W-1:0]   reg_rdata,
    input logic [NUM_CTR-1:0] frz_q
);
    logic [11:0]      c_off, s_off;
    logic             is_ctr, is_sel, is_mask, is_none, frz_bit;
    logic [CTR_W-1:0] sel_ext;
    logic [11:0]      slot_ix;

    // Independent address classification for the properties.
    always_comb begin
        c_off   = reg_addr - CTR_BASE;
        s_off   = reg_addr - SEL_BASE;
        is_ctr  = (c_off >= 12'(FIRST_IDX)) && (c_off < 12'(FIRST_IDX + NUM_CTR));
        is_sel  = (s_off >= 12'(FIRST_IDX)) && (s_off < 12'(FIRST_IDX + NUM_CTR));
        is_mask = (s_off == 12'd0);
        is_none = !is_ctr && !is_sel && !is_mask;
        slot_ix = is_ctr ? (c_off - 12'(FIRST_IDX)) : 12'd0;
        frz_bit = is_ctr ? frz_q[slot_ix[4:0]] : 1'b0;
        sel_ext = CTR_W'(reg_wdata[SEL_W-1:0]);
    end

    // R10: unmapped addresses read zero.
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        is_none |-> reg_rdata == '0);

    // R4: mask bits outside 3..31 read zero.
    assert_mask_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_mask |-> (reg_rdata[FIRST_IDX-1:0] == '0 && reg_rdata[CTR_W-1:32] == '0));

    // R3: selector reads are zero-extended from SEL_W bits.
    assert_sel_zero_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_sel |-> reg_rdata[CTR_W-1:SEL_W] == '0);

    // R3: a selector keeps the low bits of the last write.
    assert_sel_write_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sel && $past(reg_wr) && reg_addr == $past(reg_addr)) |-> reg_rdata == $past(sel_ext));

    // R8: a counter write wins over that cycle's increment.
    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctr && $past(reg_wr) && reg_addr == $past(reg_addr)) |-> reg_rdata == $past(reg_wdata));

    // R7: a frozen counter holds its value.
    assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctr && $past(is_ctr) && reg_addr == $past(reg_addr) && !$past(reg_wr) && $past(frz_bit))
        |-> reg_rdata == $past(reg_rdata));
endmodule

bind hpm_counter_bank hpm_counter_bank_chk #(
    .FIRST_IDX(FIRST_IDX),
    .NUM_CTR  (NUM_CTR),
    .CTR_W    (CTR_W),
    .SEL_W    (SEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .frz_q    (frz_q)
);

// File: tb/hpm_counter_bank_bench.sv
`timescale 1ns/1ps
module hpm_counter_bank_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [767:0] evt_lanes = '0;
    logic [11:0]  reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic [63:0]  reg_wdata = '0;
    logic [63:0]  reg_rdata;

    int checks = 0;
    int fails  = 0;

    // Bench model state, indexed by slot number 0..31 (0..2 unused).
    logic [63:0] m_ctr [32];
    logic [6:0]  m_sel [32];
    logic [31:0] m_frz;

    hpm_counter_bank u_hpm_counter_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_lanes(evt_lanes),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    always #4 clk = ~clk;

    function automatic logic [63:0] model_read(logic [11:0] a);
        if (a >= 12'hB03 && a <= 12'hB1F) return m_ctr[a - 12'hB00];
        if (a >= 12'h323 && a <= 12'h33F) return 64'(m_sel[a - 12'h320]);
        if (a == 12'h320) return 64'(m_frz);
        return 64'd0;
    endfunction

    function automatic string region_tag(logic [11:0] a);
        if (a >= 12'hB03 && a <= 12'hB1F) return "R2";
        if (a >= 12'h323 && a <= 12'h33F) return "R3";
        if (a == 12'h320) return "R4";
        return "R10";
    endfunction

    // Update the model for one clock edge, using pre-edge state.
    task automatic model_step(logic [11:0] a, logic w, logic [63:0] d, logic [767:0] ev);
        logic [63:0] nxt [32];
        for (int n = 3; n < 32; n++) begin
            logic [7:0] inc;
            inc = 8'd0;
            if (m_sel[n] != 7'd0 && int'(m_sel[n]) < 96) inc = ev[int'(m_sel[n])*8 +: 8];
            nxt[n] = m_frz[n] ? m_ctr[n] : m_ctr[n] + 64'(inc);
        end
        for (int n = 3; n < 32; n++) m_ctr[n] = nxt[n];
        if (w) begin
            if (a >= 12'hB03 && a <= 12'hB1F) m_ctr[a - 12'hB00] = d;
            if (a >= 12'h323 && a <= 12'h33F) m_sel[a - 12'h320] = d[6:0];
            if (a == 12'h320) m_frz = d[31:0] & 32'hFFFF_FFF8;
        end
    endtask

    // One cycle: drive, optionally check the current read, then take the edge.
    task automatic cyc(logic [11:0] a, logic w, logic [63:0] d, logic [767:0] ev,
                       logic chk, string tag);
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_wdata = d; evt_lanes = ev;
        #1;
        if (chk) begin
            logic [63:0] e;
            e = model_read(a);
            checks++;
            if (reg_rdata !== e) begin
                fails++;
                $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, reg_rdata, e);
            end
        end
        @(posedge clk);
        model_step(a, w, d, ev);
    endtask

    function automatic logic [767:0] lane(int k, logic [7:0] v);
        logic [767:0] r;
        r = '0;
        r[k*8 +: 8] = v;
        return r;
    endfunction

    function automatic logic [767:0] rand_lanes();
        logic [767:0] r;
        for (int i = 0; i < 24; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int n = 0; n < 32; n++) begin m_ctr[n] = '0; m_sel[n] = '0; end
        m_frz = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: everything zero after reset (lane inputs idle).
        for (int n = 3; n < 32; n++) cyc(12'hB00 + 12'(n), 0, 0, '0, 1, "R1");
        for (int n = 3; n < 32; n++) cyc(12'h320 + 12'(n), 0, 0, '0, 1, "R1");
        cyc(12'h320, 0, 0, '0, 1, "R1");

        // R5: slot 3 follows lane 5 carrying 0xFF; other lanes are noise that must not leak.
        cyc(12'h323, 1, 64'd5, '0, 0, "R5");
        cyc(12'hB03, 0, 0, lane(5, 8'hFF) | lane(6, 8'h11), 1, "R5");
        cyc(12'hB03, 0, 0, '0, 1, "R5");
        if (m_ctr[3] != 64'hFF) begin fails++; $display("FAIL R5 model=%h expected=ff", m_ctr[3]); end
        checks++;

        // R8 then R9: load near the top while lane 1 is live, then wrap.
        cyc(12'h324, 1, 64'd1, '0, 0, "R8");
        cyc(12'hB04, 1, 64'hFFFF_FFFF_FFFF_FFF0, lane(1, 8'h20), 0, "R8");
        cyc(12'hB04, 0, 0, lane(1, 8'h20), 1, "R8");
        cyc(12'hB04, 0, 0, '0, 1, "R9");
        if (m_ctr[4] != 64'h10) begin fails++; $display("FAIL R9 model=%h expected=10", m_ctr[4]); end
        checks++;

        // R6: lane 0 and selectors 0, 100, 127 contribute nothing.
        cyc(12'h326, 1, 64'd100, '0, 0, "R6");
        cyc(12'h327, 1, 64'h1FF, '0, 1, "R6");
        cyc(12'h327, 0, 0, '0, 1, "R3");
        cyc(12'hB05, 0, 0, lane(0, 8'hAA) | lane(100 % 96, 8'h01), 1, "R6");
        cyc(12'hB05, 0, 0, lane(0, 8'hAA), 1, "R6");
        cyc(12'hB06, 0, 0, '1, 1, "R6");
        cyc(12'hB07, 0, 0, '1, 1, "R6");

        // R4 and R7: full-ones mask keeps only bits 3..31 and freezes all slots.
        cyc(12'h320, 1, '1, '0, 0, "R4");
        cyc(12'h320, 0, 0, '1, 1, "R4");
        cyc(12'hB03, 0, 0, '1, 1, "R7");
        cyc(12'hB03, 0, 0, '1, 1, "R7");
        cyc(12'hB04, 0, 0, '1, 1, "R7");
        cyc(12'h320, 1, 64'h8, '1, 0, "R7");
        cyc(12'hB03, 0, 0, lane(5, 8'h03), 1, "R7");
        cyc(12'hB03, 0, 0, '0, 1, "R7");

        // R10: writes to unmapped addresses are dropped and read zero.
        cyc(12'hB00, 1, '1, '0, 1, "R10");
        cyc(12'h321, 1, '1, '0, 1, "R10");
        cyc(12'hB20, 1, '1, '0, 1, "R10");
        cyc(12'h000, 1, '1, '0, 1, "R10");
        cyc(12'hB00, 0, 0, '0, 1, "R10");
        cyc(12'h321, 0, 0, '0, 1, "R10");
        cyc(12'h320, 0, 0, '0, 1, "R4");
        for (int n = 3; n < 32; n++) cyc(12'h320 + 12'(n), 0, 0, '0, 1, "R10");

        // Random mix: every read compared with the model (R2 R3 R4 R5 R7 R8 R9 R10).
        for (int i = 0; i < 6000; i++) begin
            logic [11:0] a;
            logic [63:0] d;
            logic        w;
            int          r;
            r = int'($urandom % 10);
            if (r < 4)      a = 12'hB00 + 12'(3 + $urandom % 29);
            else if (r < 7) a = 12'h320 + 12'(3 + $urandom % 29);
            else if (r < 8) a = 12'h320;
            else            a = 12'($urandom);
            w = ($urandom % 5) == 0;
            d = {$urandom, $urandom};
            if (a >= 12'h323 && a <= 12'h33F && ($urandom % 2) == 0) d = 64'($urandom % 96);
            if (a == 12'h320 && ($urandom % 2) == 0) d = 64'($urandom % 2) << (3 + $urandom % 29);
            if (a >= 12'hB03 && a <= 12'hB1F && ($urandom % 3) == 0) d = 64'hFFFF_FFFF_FFFF_FF00 | 64'($urandom % 256);
            cyc(a, w, d, rand_lanes(), 1, region_tag(a));
        end

        // Final sweep of all counters against the model.
        for (int n = 3; n < 32; n++) cyc(12'hB00 + 12'(n), 0, 0, '0, 1, "R2");
        summary();
    end
endmodule